// File: doc/BRIEF.md
# Saturating Floating-Point Multiplier

This block multiplies two packed floating-point operands that share an 8-bit exponent field with a bias of 127. The mantissa width is a parameter. With its default of 7 the word is the 16-bit brain-float layout, and with 23 it is the 32-bit single-precision layout. The sign, exponent and mantissa of the product are formed by separate paths. The mantissa path multiplies the two significands with their hidden leading ones, renormalizes by at most one place and truncates the low bits. The exponent path adds the two fields and removes the bias.

The block does not wrap the exponent and does not flag an out-of-range result. Instead it clamps the result to the edge of the field. A result too small to represent becomes a signed zero. A result too large becomes the largest encoding, with exponent 255 and an all-ones mantissa. An operand whose exponent field is zero is treated as zero. Special values, subnormals and rounding are not handled.

The product is registered. A result presented with its valid strobe appears one clock later together with an output valid flag, and it holds until the next valid input.

Top module: `fpmul_sat`

## Requirements
- R1: For operands with non-zero exponent fields, the product sign bit (bit WORD_W-1) is the XOR of the two operand sign bits, including when the exponent is clamped.
- R2: When the significand product (1.mA × 1.mB, hidden ones included) is below 2, the exponent field (bits WORD_W-2 down to MANT_W) is expA + expB − 127 and the mantissa field (bits MANT_W-1 down to 0) is the MANT_W bits just below the product's leading one, truncated with no rounding.
- R3: When the significand product is 2 or more, the mantissa is taken one place higher (shifted right by one) and the exponent is expA + expB − 126.
- R4: When the adjusted exponent is negative, the exponent field is 0 and the mantissa field is 0, and the sign follows R1.
- R5: When the adjusted exponent exceeds 255, the exponent field is 255 and the mantissa field is all ones, and the sign follows R1.
- R6: If either operand has an exponent field of 0, the output word is all zeros.
- R7: outValid is high exactly in the cycle after a cycle with inValid high, and outProd carries that input's product in that cycle.
- R8: While inValid is low, outProd keeps its last value whatever the operands do.
- R9: After reset, outValid is 0 and outProd is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands on opA/opB are to be multiplied this cycle |
| opA | input | WORD_W | First packed operand {sign, exponent[7:0], mantissa} |
| opB | input | WORD_W | Second packed operand, same layout |
| outValid | output | 1 | outProd holds a fresh product |
| outProd | output | WORD_W | Registered packed product |

## Verification
The bench aims at the exponent edges. Operand pairs whose biased sum lands just below zero, just above 255 and exactly on each bound catch a design that wraps the exponent field, or one that checks the bounds before the renormalizing increment, which would be off by one at the edge. Significand pairs on both sides of the carry into the top product bit show whether the mantissa is taken from the wrong slice or the exponent misses its increment. Negative operands in the clamped cases show whether the sign is lost. Zero-exponent operands and idle cycles with changing operands catch a block that multiplies zeros as if they had a hidden one, or one that updates its output without a valid strobe.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;
  localparam int EXP_W    = 8;
  localparam int EXP_BIAS = 127;

  typedef struct packed {
    logic loadEn;
  } fpmulStrobes_t;
endpackage

// File: rtl/fpmul_sat_ctrl.sv
module fpmul_sat_ctrl
  import fpmul_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output fpmulStrobes_t strobes,
  output logic          outValid
);
  always_comb strobes.loadEn = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R7: valid emerges exactly one cycle after the input strobe
  p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/fpmul_sat_dp.sv
module fpmul_sat_dp
  import fpmul_pkg::*;
#(
  parameter int MANT_W = 7,
  localparam int WORD_W = 1 + EXP_W + MANT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpmulStrobes_t     strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] outProd
);
  localparam int PROD_W = 2 * MANT_W + 2;
  localparam int XW     = EXP_W + 3;

  logic              signA, signB, signOut;
  logic [EXP_W-1:0]  expA, expB;
  logic [MANT_W:0]   sigA, sigB;
  logic [PROD_W-1:0] prodFull;
  logic              carryTop;
  logic [MANT_W-1:0] mantNorm;
  logic [XW-1:0]     expRaw;
  logic              expUnder, expOver, zeroIn;
  logic [WORD_W-1:0] resultNext;
  logic              unusedLowBits;

  // field split
  assign signA = opA[WORD_W-1];
  assign signB = opB[WORD_W-1];
  assign expA  = opA[WORD_W-2 -: EXP_W];
  assign expB  = opB[WORD_W-2 -: EXP_W];
  assign sigA  = {1'b1, opA[MANT_W-1:0]};
  assign sigB  = {1'b1, opB[MANT_W-1:0]};

  // sign path
  assign signOut = signA ^ signB;

  // mantissa path: full product, one-place renormalize, truncate
  assign prodFull  = PROD_W'(sigA) * PROD_W'(sigB);
  assign carryTop  = prodFull[PROD_W-1];
  assign mantNorm  = carryTop ? prodFull[PROD_W-2 -: MANT_W]
                              : prodFull[PROD_W-3 -: MANT_W];
  assign unusedLowBits = ^prodFull[MANT_W-1:0];

  // exponent path: wide enough that neither bound wraps
  assign expRaw   = XW'(expA) + XW'(expB) + XW'(carryTop) - XW'(EXP_BIAS);
  assign expUnder = expRaw[XW-1];
  assign expOver  = !expUnder && (|expRaw[XW-2:EXP_W]);
  assign zeroIn   = (expA == '0) || (expB == '0);

  always_comb begin
    if (zeroIn)
      resultNext = '0;
    else if (expUnder)
      resultNext = {signOut, {EXP_W{1'b0}}, {MANT_W{1'b0}}};
    else if (expOver)
      resultNext = {signOut, {EXP_W{1'b1}}, {MANT_W{1'b1}}};
    else
      resultNext = {signOut, expRaw[EXP_W-1:0], mantNorm};
  end

  always_ff @(posedge clk) begin
    if (!rstN)               outProd <= '0;
    else if (strobes.loadEn) outProd <= resultNext;
  end

  // R8: no load, no change
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(outProd));

  // R6: zero exponent operand clears the word
  p_zero_operand_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEn && (expA == '0 || expB == '0)) |=> (outProd == '0));

  // R1: sign of a non-zero product
  p_sign_xor_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEn && expA != '0 && expB != '0)
      |=> (outProd[WORD_W-1] == $past(opA[WORD_W-1] ^ opB[WORD_W-1])));

  // R5: sum so large that it overflows even without the carry
  p_clamp_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEn && ({1'b0, expA} + {1'b0, expB}) >= 9'd383)
      |=> (outProd[WORD_W-2:0] == '1));

  // R4: sum so small that it underflows even with the carry
  p_clamp_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEn && expA != '0 && expB != '0
       && ({1'b0, expA} + {1'b0, expB}) < 9'd126)
      |=> (outProd[WORD_W-2:0] == '0));
endmodule

// File: rtl/fpmul_sat.sv
module fpmul_sat
  import fpmul_pkg::*;
#(
  parameter int MANT_W = 7,
  localparam int WORD_W = 1 + EXP_W + MANT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] outProd
);
  fpmulStrobes_t strobes;

  fpmul_sat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fpmul_sat_dp #(.MANT_W(MANT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .outProd (outProd)
  );

  // R9: reset state is visible in the first cycle after reset
  p_reset_clear_r9: assert property (@(posedge clk)
    !rstN |=> (!outValid && outProd == '0));
endmodule

// File: tb/fpmul_sat_test.sv
module fpmul_sat_test;
  localparam int M = 7;
  localparam int W = 1 + 8 + M;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         outValid;
  logic [W-1:0] outProd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fpmul_sat #(.MANT_W(M)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .opA(opA), .opB(opB), .outValid(outValid), .outProd(outProd)
  );

  function automatic logic [W-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    int ea, eb, e;
    longint sa, sb, p, one, mant;
    logic s;
    ea = int'(a[W-2 -: 8]);
    eb = int'(b[W-2 -: 8]);
    if (ea == 0 || eb == 0) return '0;
    s   = a[W-1] ^ b[W-1];
    one = longint'(1) << M;
    sa  = one + longint'(a[M-1:0]);
    sb  = one + longint'(b[M-1:0]);
    p   = sa * sb;
    e   = ea + eb - 127;
    if (p >= (longint'(2) << (2 * M))) begin
      e++;
      mant = (p >> (M + 1)) % one;
    end else begin
      mant = (p >> M) % one;
    end
    if (e < 0)   return {s, 8'h00, {M{1'b0}}};
    if (e > 255) return {s, 8'hFF, {M{1'b1}}};
    return {s, 8'(e), M'(mant)};
  endfunction

  function automatic string tagOf(input logic [W-1:0] a, input logic [W-1:0] b);
    int e;
    longint p;
    if (a[W-2 -: 8] == 0 || b[W-2 -: 8] == 0) return "R6";
    p = ((longint'(1) << M) + longint'(a[M-1:0])) * ((longint'(1) << M) + longint'(b[M-1:0]));
    e = int'(a[W-2 -: 8]) + int'(b[W-2 -: 8]) - 127 + ((p >= (longint'(2) << (2 * M))) ? 1 : 0);
    if (e < 0)   return "R4";
    if (e > 255) return "R5";
    if (p >= (longint'(2) << (2 * M))) return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // drive at a falling edge, read the registered result one falling edge later
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W-1:0] exp;
    exp = refMul(a, b);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    check({req, " R7 valid"}, {{(W-1){1'b0}}, outValid}, {{(W-1){1'b0}}, 1'b1});
    check(req, outProd, exp);
    if (a[W-2 -: 8] != 0 && b[W-2 -: 8] != 0)
      check("R1 sign", {{(W-1){1'b0}}, outProd[W-1]}, {{(W-1){1'b0}}, a[W-1] ^ b[W-1]});
    inValid = 1'b0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired got=%0d expected=<100000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset valid", {{(W-1){1'b0}}, outValid}, '0);
    check("R9 reset product", outProd, '0);
    rstN = 1'b1;

    // directed cases (brain-float layout)
    runOp(16'h3F80, 16'h3F80, "R2 one*one");
    check("R2 literal", outProd, 16'h3F80);
    runOp(16'h3FC0, 16'h3FC0, "R3 1.5*1.5");
    check("R3 literal", outProd, 16'h4010);
    runOp(16'hC000, 16'h4040, "R2 -2*3");
    check("R1 literal", outProd, 16'hC0C0);
    runOp(16'h7F00, 16'h7F00, "R5 huge");
    check("R5 literal", outProd, 16'h7FFF);
    runOp(16'hFF00, 16'h7F00, "R5 negative huge");
    check("R5 literal sign", outProd, 16'hFFFF);
    runOp(16'h0080, 16'h0080, "R4 tiny");
    check("R4 literal", outProd, 16'h0000);
    runOp(16'h8080, 16'h0080, "R4 negative tiny");
    check("R4 literal sign", outProd, 16'h8000);
    runOp(16'h0000, 16'h4000, "R6 zero a");
    runOp(16'hC040, 16'h8055, "R6 zero b");
    check("R6 literal", outProd, 16'h0000);
    // exponent bounds with and without the renormalizing carry
    runOp({1'b0, 8'd191, 7'h00}, {1'b0, 8'd191, 7'h00}, "R2 exp exactly 255");
    runOp({1'b0, 8'd191, 7'h7F}, {1'b0, 8'd191, 7'h7F}, "R5 carry pushes past 255");
    runOp({1'b0, 8'd63, 7'h00}, {1'b0, 8'd64, 7'h00}, "R2 exp exactly 0");
    runOp({1'b0, 8'd63, 7'h7F}, {1'b0, 8'd63, 7'h7F}, "R3 carry lifts -1 to 0");
    runOp({1'b0, 8'd63, 7'h00}, {1'b0, 8'd63, 7'h00}, "R4 exp -1");
    runOp({1'b0, 8'd127, 7'h7F}, {1'b0, 8'd127, 7'h01}, "R3 truncation");

    // R8: idle cycles with moving operands leave the output alone
    held = outProd;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      opA = W'($urandom);
      opB = W'($urandom);
      @(negedge clk);
      check("R8 hold product", outProd, held);
      check("R7 idle valid", {{(W-1){1'b0}}, outValid}, '0);
    end

    // constrained random: exponents mostly near the bias, some anywhere
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (($urandom % 4) != 0) begin
        a[W-2 -: 8] = 8'(96 + ($urandom % 64));
        b[W-2 -: 8] = 8'(96 + ($urandom % 64));
      end
      runOp(a, b, tagOf(a, b));
    end

    // back-to-back valids
    @(negedge clk);
    opA = 16'h4000; opB = 16'h4000; inValid = 1'b1;
    @(negedge clk);
    check("R7 back-to-back first", outProd, 16'h4080);
    opA = 16'h4040; opB = 16'hBF80;
    @(negedge clk);
    check("R7 back-to-back second", outProd, 16'hC040);
    check("R7 back-to-back valid", {{(W-1){1'b0}}, outValid}, {{(W-1){1'b0}}, 1'b1});
    inValid = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule